// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits between a synchronous on-chip read port and an external parallel NOR-type flash that has no clock of its own. A word read request (address with a valid/ready handshake) is turned into the flash's asynchronous read timing. The block drives the word address, the active-low chip enable and output enable, and keeps write enable high. It waits a fixed number of clock cycles for the flash data to settle, samples the data bus, and returns the word with a one-cycle valid strobe.

The flash delivers words of an already open four-word page much faster than a word from a fresh location. The controller therefore remembers which page is open. A request whose upper address bits match that page, while chip enable has stayed low, is timed with the short page latency. Any other request is timed with the full initial latency: a new page, the first read after reset, or the first read after chip enable was let go. Chip enable is released after a set number of idle cycles, and that closes the page. All latencies are parameters counted in clock cycles. Only one read is in flight at a time.

Top module: `pfr_page_reader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `fl_we_n` is 1 in every cycle, including every cycle in which `fl_ce_n` is 0.
- R3: From the cycle after a request is accepted until its response, `fl_ce_n` and `fl_oe_n` are both 0.
- R4: A read to a page that is not open (including the first read after reset) raises `rsp_valid` exactly T_ACC_CYC clock edges after the accepting edge, with the word the flash drives for that address.
- R5: A read whose address bits above the low PAGE_BITS (2 by default, selecting one of 4 words) match the open page, with chip enable held low since that page was opened, raises `rsp_valid` exactly T_PAGE_CYC edges after acceptance, with the correct word. Any number of such hits may follow one another.
- R6: A read to a different page while chip enable is low, including the adjacent page, takes the full T_ACC_CYC latency.
- R7: After IDLE_CYC consecutive idle edges with the page open, `fl_ce_n` and `fl_oe_n` go to 1 and the page closes, so the next read takes T_ACC_CYC even within the same page. After IDLE_CYC-1 idle edges chip enable is still low and a same-page read is still a hit.
- R8: `req_ready` is 0 from the edge that accepts a request until the response. A request offered during that time is not taken, and the response carries the first address's word.
- R9: `rsp_valid` is high for exactly one cycle per accepted request.
- R10: `fl_addr` holds the accepted address, unchanged, throughout the access.
- R11: Reset closes the open page. The first read after reset to the previously open page takes T_ACC_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` holds the read word |
| rsp_data | output | DATA_W | Word read from the flash |
| fl_addr | output | ADDR_W | Word address to the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low (held high) |
| fl_dq | input | DATA_W | Flash data bus |

## Verification
The hardest situation to reach is the exact edge of the idle release. A same-page read after IDLE_CYC-1 idle cycles must still be a hit, and one after IDLE_CYC idle cycles must be a miss. Only the gap between a response and the next request separates the two. The stimulus table therefore walks a run of reads with chosen gaps that straddle this limit, with page changes between them. A behavioural flash model returns a corrupted word until the hit or miss latency it computes on its own has passed. A controller that samples one cycle early, or that misjudges whether the page is open, then returns the wrong word as well as the wrong latency.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_READ = 1'b1
   } pfr_state_e;
endpackage

// File: rtl/pfr_page_tracker.sv
// Remembers the tag of the page left open on the flash and reports a hit.
module pfr_page_tracker #(
   parameter int TAG_W        = 18,
   parameter bit PAGE_MODE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] lookup_tag,
   input  logic             commit,
   input  logic [TAG_W-1:0] commit_tag,
   input  logic             close,
   output logic             hit,
   output logic             open
);
   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      open_q <= 1'b0;
      else if (commit) open_q <= 1'b1;
      else if (close)  open_q <= 1'b0;
   end

   assign open = open_q;

   generate
      if (PAGE_MODE_EN) begin : g_page
         logic [TAG_W-1:0] tag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      tag_q <= '0;
            else if (commit) tag_q <= commit_tag;
         end
         assign hit = open_q && (tag_q == lookup_tag);
      end else begin : g_nopage
         assign hit = 1'b0;
      end
   endgenerate

   // a commit always leaves the page open on the next cycle
   assert_commit_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> open);
endmodule

// File: rtl/pfr_latency_timer.sv
// Counts the flash access latency; last is high on the sampling cycle.
module pfr_latency_timer #(
   parameter int T_ACC_CYC  = 7,
   parameter int T_PAGE_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic use_page,
   output logic last
);
   localparam int CNT_W = $clog2(T_ACC_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD_ACC  = CNT_W'(T_ACC_CYC);
   localparam logic [CNT_W-1:0] LOAD_PAGE = CNT_W'(T_PAGE_CYC);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= use_page ? LOAD_PAGE : LOAD_ACC;
      else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
   end

   assign last = (cnt_q == ONE);

   // a new access only starts once the previous one has run out
   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (cnt_q == '0));
   // the loaded latency is one of the two allowed values
   assert_latency_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == LOAD_ACC || cnt_q == LOAD_PAGE));
endmodule

// File: rtl/pfr_idle_timer.sv
// Counts idle cycles with chip enable low; expire asks for release.
module pfr_idle_timer #(
   parameter int IDLE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int IW = $clog2(IDLE_CYC + 1);
   localparam logic [IW-1:0] LAST = IW'(IDLE_CYC - 1);
   localparam logic [IW-1:0] ONE  = IW'(1);

   logic [IW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (expire) cnt_q <= '0;
      else             cnt_q <= cnt_q + ONE;
   end

   assign expire = run && (cnt_q == LAST);

   // the count never passes the release point
   assert_idle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/pfr_page_reader.sv
// Page-mode read controller for an asynchronous parallel flash.
module pfr_page_reader
   import pfr_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 16,
   parameter int PAGE_BITS    = 2,
   parameter bit PAGE_MODE_EN = 1'b1,
   parameter int T_ACC_CYC    = 7,
   parameter int T_PAGE_CYC   = 3,
   parameter int IDLE_CYC     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] fl_addr,
   output logic              fl_ce_n,
   output logic              fl_oe_n,
   output logic              fl_we_n,
   input  logic [DATA_W-1:0] fl_dq
);
   localparam int TAG_W = ADDR_W - PAGE_BITS;

   generate
      if (T_PAGE_CYC < 1) begin : g_bad_page
         $error("T_PAGE_CYC must be at least 1");
      end
      if (T_ACC_CYC < T_PAGE_CYC) begin : g_bad_acc
         $error("T_ACC_CYC must not be below T_PAGE_CYC");
      end
      if (IDLE_CYC < 1) begin : g_bad_idle
         $error("IDLE_CYC must be at least 1");
      end
      if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page_bits
         $error("PAGE_BITS must lie between 1 and ADDR_W-1");
      end
   endgenerate

   pfr_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ce_n_q, oe_n_q, rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;
   logic              accept, lat_last, page_hit, page_open, idle_expire;
   logic              idle_run, release_ce, done;

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign done       = (state_q == ST_READ) && lat_last;
   assign idle_run   = (state_q == ST_IDLE) && !ce_n_q && !accept;
   assign release_ce = idle_expire;

   pfr_page_tracker #(
      .TAG_W       (TAG_W),
      .PAGE_MODE_EN(PAGE_MODE_EN)
   ) u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .lookup_tag(req_addr[ADDR_W-1:PAGE_BITS]),
      .commit    (done),
      .commit_tag(addr_q[ADDR_W-1:PAGE_BITS]),
      .close     (release_ce),
      .hit       (page_hit),
      .open      (page_open)
   );

   pfr_latency_timer #(
      .T_ACC_CYC (T_ACC_CYC),
      .T_PAGE_CYC(T_PAGE_CYC)
   ) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .use_page(page_hit),
      .last    (lat_last)
   );

   pfr_idle_timer #(
      .IDLE_CYC(IDLE_CYC)
   ) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (idle_run),
      .expire(idle_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         ce_n_q      <= 1'b1;
         oe_n_q      <= 1'b1;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         if (accept) begin
            addr_q  <= req_addr;
            ce_n_q  <= 1'b0;
            oe_n_q  <= 1'b0;
            state_q <= ST_READ;
         end else if (done) begin
            rsp_data_q  <= fl_dq;
            rsp_valid_q <= 1'b1;
            state_q     <= ST_IDLE;
         end else if (release_ce) begin
            ce_n_q <= 1'b1;
            oe_n_q <= 1'b1;
         end
      end
   end

   assign fl_addr   = addr_q;
   assign fl_ce_n   = ce_n_q;
   assign fl_oe_n   = oe_n_q;
   assign fl_we_n   = 1'b1;
   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;

   assert_enables_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ) |-> (!fl_ce_n && !fl_oe_n));
   assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_READ) && !lat_last) |=> $stable(fl_addr));
   assert_open_needs_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
      page_open |-> !fl_ce_n);
endmodule

// File: tb/pfr_page_reader_test.sv
`timescale 1ns/1ps
module pfr_page_reader_test;
   localparam int AW    = 20;
   localparam int DW    = 16;
   localparam int TACC  = 7;
   localparam int TPAGE = 3;
   localparam int TIDLE = 8;
   localparam int NV    = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic rsp_valid;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] fl_addr;
   logic fl_ce_n, fl_oe_n, fl_we_n;
   logic [DW-1:0] fl_dq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pfr_page_reader #(
      .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(2), .PAGE_MODE_EN(1'b1),
      .T_ACC_CYC(TACC), .T_PAGE_CYC(TPAGE), .IDLE_CYC(TIDLE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
      .fl_we_n(fl_we_n), .fl_dq(fl_dq)
   );

   // contents of the flash array
   function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a);
      return a[15:0] ^ {a[19:16], a[19:16], a[19:16], a[19:16]} ^ 16'h3C5A;
   endfunction

   // behavioural flash: wrong word until the hit/miss latency has elapsed
   int m_age = 0;
   int m_need = TACC;
   int m_we_err = 0;
   bit m_off = 1'b1;
   logic [AW-1:0] m_last = '0;

   always @(negedge clk) begin
      if (!fl_ce_n && !fl_we_n) m_we_err++;
      if (fl_ce_n) begin
         m_off = 1'b1;
         m_age = 0;
      end else if (m_off || fl_addr != m_last) begin
         m_need = (m_off || fl_addr[AW-1:2] != m_last[AW-1:2]) ? TACC : TPAGE;
         m_age  = 1;
         m_off  = 1'b0;
      end else if (m_age < 1000) begin
         m_age++;
      end
      m_last = fl_addr;
   end

   assign fl_dq = (!fl_ce_n && !fl_oe_n && m_age >= m_need) ?
                  flash_word(fl_addr) : ~flash_word(fl_addr);

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // issue one read after gap idle cycles; starts and ends at a negedge
   task automatic do_read(input logic [AW-1:0] a, input int gap,
                          input int lat, input string req);
      int n = 0;
      bit rdy_ok = 1'b1;
      bit en_ok = 1'b1;
      repeat (gap) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk); #1;
      req_valid = 1'b0;
      while (!rsp_valid && n < 100) begin
         if (req_ready) rdy_ok = 1'b0;
         if (fl_ce_n || fl_oe_n || !fl_we_n) en_ok = 1'b0;
         @(posedge clk); #1;
         n++;
      end
      check(n == lat, req, "latency", n, lat);
      check(rsp_data == flash_word(a), req, "data", rsp_data, flash_word(a));
      check(rdy_ok, "R8", "ready low while busy", rdy_ok, 1);
      check(en_ok, "R3", "ce/oe low, we high while busy", en_ok, 1);
      @(negedge clk);
   endtask

   localparam logic [AW-1:0] V_ADDR [NV] = '{
      20'h00100, 20'h00101, 20'h00103, 20'h00102, 20'h00100,
      20'h00104, 20'h00105, 20'h00106, 20'h40106, 20'h40107,
      20'h40108, 20'hFFFFF, 20'hFFFFC };
   localparam int V_GAP [NV] = '{ 0, 0, 2, 1, 0, 0, 3, 7, 0, 8, 0, 0, 1 };
   localparam int V_LAT [NV] = '{ TACC, TPAGE, TPAGE, TPAGE, TPAGE,
                                  TACC, TPAGE, TPAGE, TACC, TACC,
                                  TACC, TACC, TPAGE };
   localparam string V_REQ [NV] = '{ "R4", "R5", "R5", "R5", "R5",
                                     "R6", "R5", "R7", "R6", "R7",
                                     "R6", "R6", "R5" };

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R9 actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(fl_ce_n && fl_oe_n && fl_we_n, "R1", "enables in reset",
            {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
      check(req_ready && !rsp_valid, "R1", "handshake in reset",
            {req_ready, rsp_valid}, 2'b10);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(fl_ce_n && req_ready && !rsp_valid, "R1", "after reset",
            {fl_ce_n, req_ready, rsp_valid}, 3'b110);
      @(negedge clk);

      // table of reads: gaps straddle the idle release, pages change
      for (int i = 0; i < NV; i++)
         do_read(V_ADDR[i], V_GAP[i], V_LAT[i], V_REQ[i]);

      // R8 and R10: second request offered while busy is not taken
      req_valid = 1'b1;
      req_addr  = 20'h23450;
      begin
         int n = 0;
         bit hold_ok = 1'b1;
         @(posedge clk); #1;
         req_addr = 20'h23452;
         while (!rsp_valid && n < 100) begin
            if (fl_addr != 20'h23450) hold_ok = 1'b0;
            @(posedge clk); #1;
            n++;
         end
         check(hold_ok, "R10", "address held", hold_ok, 1);
         check(n == TACC, "R8", "latency of first request", n, TACC);
         check(rsp_data == flash_word(20'h23450), "R8", "first word returned",
               rsp_data, flash_word(20'h23450));
      end
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #1;
      check(!rsp_valid, "R9", "strobe one cycle", rsp_valid, 0);
      check(req_ready, "R8", "late request not taken", req_ready, 1);
      @(negedge clk);

      // R11: reset closes the open page
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check(fl_ce_n, "R11", "ce released by reset", fl_ce_n, 1);
      @(negedge clk);
      do_read(20'h23451, 0, TACC, "R11");

      // R7: exact release point of chip enable
      repeat (TIDLE - 1) @(negedge clk);
      check(!fl_ce_n, "R7", "ce still low one short", fl_ce_n, 0);
      @(negedge clk);
      check(fl_ce_n && fl_oe_n, "R7", "ce/oe released",
            {fl_ce_n, fl_oe_n}, 2'b11);

      // R2: write enable never seen low with chip enable low
      check(m_we_err == 0, "R2", "we low during enable", m_we_err, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule